// File: doc/BRIEF.md
# Supervisor Timer-Compare Access Gate

This block decides, in the same cycle, what happens when software touches one of the supervisor timer-compare CSR addresses. It takes the hart's current privilege level and the virtualization flag, plus four control bits: the timer bit of the machine counter-enable register, the timer bit of the hypervisor counter-enable register, and the timer-compare enable bits of the machine and hypervisor environment configuration registers. It returns exactly one of three verdicts: allow, illegal-instruction, or virtual-instruction.

The verdict depends on which layer stops the access. The machine layer holds the machine counter-enable bit and the machine configuration enable bit. If that layer blocks, the result is an illegal-instruction exception. The hypervisor layer is checked only for virtualized supervisor accesses. If that layer blocks, the result is a virtual-instruction exception.

When a virtualized access is allowed, the block redirects the CSR address to the virtual-supervisor compare register. The redirected address is the incoming address plus a parameterised offset. The block also exports the effective value of the hypervisor enable bit, which is masked by the machine enable bit.

The block is purely combinational. It has no data stream and no handshake. CSR storage and trap entry belong to the surrounding logic.

Top module: `tcmp_access_chk`

## Requirements
- R1: When `priv_mode` is 2'b11 (machine), `acc_allow` is 1 for every value of the other inputs, and `tgt_addr` equals `csr_addr` even if `virt_on` is 1.
- R2: When `priv_mode` is 2'b00 (user) or 2'b10 (reserved), `acc_illegal` is 1, whatever the values of `virt_on` and the four control bits.
- R3: When `priv_mode` is 2'b01 (supervisor) and `mcnt_tm` is 0, `acc_illegal` is 1.
- R4: When `priv_mode` is 2'b01 and `menv_tce` is 0, `acc_illegal` is 1. This holds even when `virt_on` is 1 and a hypervisor bit is also 0, so an illegal-instruction verdict takes precedence over a virtual-instruction verdict.
- R5: When `priv_mode` is 2'b01, `virt_on` is 1, `mcnt_tm` and `menv_tce` are 1, and `hcnt_tm` is 0, `acc_virtual` is 1.
- R6: When `priv_mode` is 2'b01, `virt_on` is 1, `mcnt_tm` and `menv_tce` are 1, and `henv_tce` is 0, `acc_virtual` is 1.
- R7: When `priv_mode` is 2'b01, `virt_on` is 0, and `mcnt_tm` and `menv_tce` are 1, `acc_allow` is 1. In this case `hcnt_tm` and `henv_tce` have no effect on any output, and `tgt_addr` equals `csr_addr`.
- R8: `tgt_addr` equals `csr_addr + VIRT_OFFSET` (default 12'h100) exactly when the access is allowed, `priv_mode` is 2'b01 and `virt_on` is 1. In every other case `tgt_addr` equals `csr_addr`.
- R9: `henv_tce_eff` equals `henv_tce AND menv_tce`.
- R10: For every input combination, exactly one of `acc_allow`, `acc_illegal` and `acc_virtual` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_mode | input | 2 | Current privilege level: 00 user, 01 supervisor, 11 machine, 10 reserved |
| virt_on | input | 1 | Virtualization flag V |
| mcnt_tm | input | 1 | Timer bit of the machine counter-enable register |
| hcnt_tm | input | 1 | Timer bit of the hypervisor counter-enable register |
| menv_tce | input | 1 | Timer-compare enable bit of the machine environment configuration register |
| henv_tce | input | 1 | Timer-compare enable bit of the hypervisor environment configuration register, as stored |
| csr_addr | input | ADDR_W | Supervisor timer-compare address being accessed (low or high half) |
| acc_allow | output | 1 | The access proceeds |
| acc_illegal | output | 1 | The access raises an illegal-instruction exception |
| acc_virtual | output | 1 | The access raises a virtual-instruction exception |
| tgt_addr | output | ADDR_W | Address actually accessed after redirection |
| henv_tce_eff | output | 1 | Effective (read) value of the hypervisor enable bit |

## Verification
The machine layer and the hypervisor layer can both block the same access. A typical case is a virtualized supervisor access with `menv_tce` at 0 and `hcnt_tm` also at 0. The verdict must then be illegal-instruction, never virtual-instruction.

The bench provokes this collision by sweeping every combination of privilege, V, the four control bits and both compare addresses. It judges each vector against a verdict computed from the layer ordering. On every vector it also confirms that exactly one verdict line is high.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  typedef enum logic [1:0] {
    PRV_U   = 2'b00,
    PRV_S   = 2'b01,
    PRV_RSV = 2'b10,
    PRV_M   = 2'b11
  } priv_e;
endpackage

// File: rtl/tcmp_mgate.sv
module tcmp_mgate
  import tcmp_pkg::*;
(
  input  logic [1:0] priv_mode,
  input  logic       mcnt_tm,
  input  logic       menv_tce,
  output logic       is_mach,
  output logic       sup_pass,
  output logic       m_block
);
  logic is_sup;

  always_comb begin
    is_mach  = (priv_mode == PRV_M);
    is_sup   = (priv_mode == PRV_S);
    sup_pass = is_sup & mcnt_tm & menv_tce;
    m_block  = ~is_mach & ~sup_pass;
  end
endmodule

// File: rtl/tcmp_hgate.sv
module tcmp_hgate
  import tcmp_pkg::*;
#(
  parameter bit HAS_HYP = 1'b1
) (
  input  logic [1:0] priv_mode,
  input  logic       virt_on,
  input  logic       hcnt_tm,
  input  logic       henv_tce,
  input  logic       menv_tce,
  output logic       virt_eff,
  output logic       henv_eff,
  output logic       h_block
);
  generate
    if (HAS_HYP) begin : g_hyp
      always_comb begin
        virt_eff = virt_on & (priv_mode != PRV_M);
        henv_eff = henv_tce & menv_tce;
        h_block  = virt_eff & ~(hcnt_tm & henv_eff);
      end
    end else begin : g_nohyp
      logic unused_h;
      always_comb begin
        unused_h = virt_on ^ hcnt_tm ^ henv_tce ^ menv_tce ^ (^priv_mode);
        virt_eff = 1'b0;
        henv_eff = 1'b0;
        h_block  = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/tcmp_route.sv
module tcmp_route #(
  parameter int              ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] VIRT_OFFSET = 12'h100
) (
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              redirect,
  output logic [ADDR_W-1:0] tgt_addr
);
  always_comb begin
    tgt_addr = redirect ? (csr_addr + VIRT_OFFSET) : csr_addr;
  end
endmodule

// File: rtl/tcmp_access_chk.sv
module tcmp_access_chk
  import tcmp_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] VIRT_OFFSET = 12'h100,
  parameter bit                HAS_HYP     = 1'b1
) (
  input  logic [1:0]        priv_mode,
  input  logic              virt_on,
  input  logic              mcnt_tm,
  input  logic              hcnt_tm,
  input  logic              menv_tce,
  input  logic              henv_tce,
  input  logic [ADDR_W-1:0] csr_addr,
  output logic              acc_allow,
  output logic              acc_illegal,
  output logic              acc_virtual,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              henv_tce_eff
);
  logic is_mach, sup_pass, m_block;
  logic virt_eff, henv_eff, h_block;
  logic redirect;

  tcmp_mgate u_mgate (
    .priv_mode (priv_mode),
    .mcnt_tm   (mcnt_tm),
    .menv_tce  (menv_tce),
    .is_mach   (is_mach),
    .sup_pass  (sup_pass),
    .m_block   (m_block)
  );

  tcmp_hgate #(.HAS_HYP(HAS_HYP)) u_hgate (
    .priv_mode (priv_mode),
    .virt_on   (virt_on),
    .hcnt_tm   (hcnt_tm),
    .henv_tce  (henv_tce),
    .menv_tce  (menv_tce),
    .virt_eff  (virt_eff),
    .henv_eff  (henv_eff),
    .h_block   (h_block)
  );

  // Machine layer first: its block always wins over the hypervisor layer.
  always_comb begin
    acc_illegal  = m_block;
    acc_virtual  = sup_pass & h_block;
    acc_allow    = is_mach | (sup_pass & ~h_block);
    redirect     = sup_pass & ~h_block & virt_eff;
    henv_tce_eff = henv_eff;
  end

  tcmp_route #(.ADDR_W(ADDR_W), .VIRT_OFFSET(VIRT_OFFSET)) u_route (
    .csr_addr (csr_addr),
    .redirect (redirect),
    .tgt_addr (tgt_addr)
  );

  always_comb begin
    AST_ONE_VERDICT: assert ($countones({acc_allow, acc_illegal, acc_virtual}) == 1); // R10
    AST_MACH_ALLOWED: assert (!is_mach || (acc_allow && tgt_addr == csr_addr)); // R1
    AST_HENV_MASKED: assert (!henv_tce_eff || menv_tce); // R9
    AST_REDIRECT_ONLY_ALLOWED: assert (tgt_addr == csr_addr || (acc_allow && virt_on)); // R8
    AST_MBLOCK_NOT_VIRTUAL: assert (!(acc_virtual && !menv_tce)); // R4
  end
endmodule

// File: tb/tb_tcmp_access_chk.sv
module tb_tcmp_access_chk;
  localparam int ADDR_W = 12;

  typedef struct packed {
    logic [2:0]        verdict;  // {allow, illegal, virtual}
    logic [ADDR_W-1:0] tgt;
    logic              heff;
    logic [3:0]        tag;      // requirement that set the verdict
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]        priv_mode = 2'b00;
  logic              virt_on = 1'b0, mcnt_tm = 1'b0, hcnt_tm = 1'b0;
  logic              menv_tce = 1'b0, henv_tce = 1'b0;
  logic [ADDR_W-1:0] csr_addr = 12'h14D;
  logic              acc_allow, acc_illegal, acc_virtual, henv_tce_eff;
  logic [ADDR_W-1:0] tgt_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t sb_q[$];

  tcmp_access_chk dut (
    .priv_mode(priv_mode), .virt_on(virt_on), .mcnt_tm(mcnt_tm),
    .hcnt_tm(hcnt_tm), .menv_tce(menv_tce), .henv_tce(henv_tce),
    .csr_addr(csr_addr), .acc_allow(acc_allow), .acc_illegal(acc_illegal),
    .acc_virtual(acc_virtual), .tgt_addr(tgt_addr), .henv_tce_eff(henv_tce_eff)
  );

  function automatic exp_t model(logic [1:0] p, logic v, logic mc, logic hc,
                                 logic me, logic he, logic [ADDR_W-1:0] a);
    exp_t e;
    e.heff = he & me;                                  // R9
    e.tgt  = a;
    if (p == 2'b11) begin e.verdict = 3'b100; e.tag = 4'd1; end       // R1
    else if (p != 2'b01) begin e.verdict = 3'b010; e.tag = 4'd2; end  // R2
    else if (!mc) begin e.verdict = 3'b010; e.tag = 4'd3; end         // R3
    else if (!me) begin e.verdict = 3'b010; e.tag = 4'd4; end         // R4
    else if (!v) begin e.verdict = 3'b100; e.tag = 4'd7; end          // R7
    else if (!hc) begin e.verdict = 3'b001; e.tag = 4'd5; end         // R5
    else if (!he) begin e.verdict = 3'b001; e.tag = 4'd6; end         // R6
    else begin e.verdict = 3'b100; e.tag = 4'd8; e.tgt = a + 12'h100; end // R8
    return e;
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] p, logic v, logic mc, logic hc,
                       logic me, logic he, logic [ADDR_W-1:0] a);
    @(posedge clk);
    #1;
    sb_q.push_back(model(p, v, mc, hc, me, he, a));
    priv_mode = p; virt_on = v; mcnt_tm = mc; hcnt_tm = hc;
    menv_tce = me; henv_tce = he; csr_addr = a;
  endtask

  // Monitor: pops one expected item per driven vector, mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        logic [2:0] got;
        string rq;
        e = sb_q.pop_front();
        got = {acc_allow, acc_illegal, acc_virtual};
        rq = $sformatf("R%0d", e.tag);
        check(got == e.verdict, rq, {13'd0, got}, {13'd0, e.verdict});
        check($countones(got) == 1, "R10", {13'd0, got}, 16'd1);
        check(tgt_addr == e.tgt, (e.tag == 4'd8) ? "R8" : "R8 no-redirect",
              {4'd0, tgt_addr}, {4'd0, e.tgt});
        check(henv_tce_eff == e.heff, "R9", {15'd0, henv_tce_eff}, {15'd0, e.heff});
      end
    end
  end

  initial begin
    #2000000;
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset-state inputs are all zero: user mode, expected illegal (R2).
    check({acc_allow, acc_illegal, acc_virtual} == 3'b010, "R2 reset",
          {13'd0, acc_allow, acc_illegal, acc_virtual}, 16'h2);
    // Directed collision: both layers block, illegal wins (R4).
    drive(2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'h14D);
    // Exhaustive sweep over every input combination (R10).
    for (int i = 0; i < 256; i++) begin
      drive(i[1:0], i[2], i[3], i[4], i[5], i[6], i[7] ? 12'h15D : 12'h14D);
    end
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    check(sb_q.size() == 0, "R10 scoreboard drained", sb_q.size(), 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule